// File: doc/BRIEF.md
# Polling Wake-Up Bitcheck Gate

This block decides when a low-rate receiver running in polling mode should wake up. It steps through three polling phases: sleep, startup and bitcheck. Sleep and startup each last a programmable number of ticks of an extended clock. During bitcheck it measures the time between level changes of the demodulated bit stream, counting in the same ticks. Each interval stands for half of a Manchester or bi-phase bit and must fall inside a programmable window. An interval that is too short, or a wait that runs too long, sends the block straight back to sleep. Random noise from an idle channel therefore usually ends the check after a few edges.

When the programmed number of intervals has passed in a row, the block enters receiving mode. There it raises the routing select and passes the sampled demodulator bit to its data output. It stays in receiving mode until the host issues a return-to-polling command. The window limits and the interval count are captured only while the block sleeps, so a check in progress always runs against one fixed set of values.

Top module: `poll_wake_gate`

## Requirements
- R1: After reset, mode is 0 (sleep), rx_en is 0, data_sel is 0 and data_out is 1.
- R2: Mode codes are 0 sleep, 1 startup, 2 bitcheck, 3 receiving, and mode changes only on a clock edge where tick is high. Sleep lasts sleep_len ticks, after which startup lasts start_len ticks and is followed by bitcheck. rx_en is 1 in every mode except sleep.
- R3: Toggling demod_in during startup has no effect on the sequence.
- R4: In bitcheck, the first level change only starts the interval counter. Before that first change, no amount of waiting ends the check.
- R5: An interval D, counted in ticks between two sampled level changes, with D < lim_lo ends the check, and mode returns to 0 on that tick.
- R6: If no level change arrives within lim_hi-1 ticks of the previous one, mode returns to 0 on tick lim_hi-1.
- R7: An interval with lim_lo <= D <= lim_hi-1 passes. When bits_req consecutive intervals have passed, mode becomes 3 and data_sel becomes 1 on that tick.
- R8: In receiving mode, data_out shows the level of demod_in sampled on the latest tick, one clock after that tick. In every other mode data_out is 1.
- R9: Receiving mode never ends on its own. A tick with poll_cmd high in receiving mode returns the block to sleep, and poll_cmd has no effect in the other modes.
- R10: lim_lo, lim_hi and bits_req are captured only while in sleep. Changing them in other modes does not affect the check in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Extended clock tick, one clk cycle wide |
| demod_in | input | 1 | Demodulated data bit |
| lim_lo | input | CW | Shortest accepted interval, in ticks |
| lim_hi | input | CW | Interval length that counts as too long, in ticks |
| bits_req | input | BW | Number of passing intervals needed to wake |
| sleep_len | input | DW | Sleep duration, in ticks |
| start_len | input | DW | Startup duration, in ticks |
| poll_cmd | input | 1 | Return-to-polling command, sampled on ticks |
| rx_en | output | 1 | Receiver enable |
| mode | output | 2 | Current mode code |
| data_sel | output | 1 | High when the data output carries received data |
| data_out | output | 1 | Routed data, idle high |

## Verification
The assertions check on every cycle the legal mode transitions: sleep goes only to startup, startup goes only to bitcheck, and receiving mode is reached only from bitcheck. They also check that mode holds between ticks, that receiving mode persists without a command, and that the interval counter stays below the upper limit. Only the bench scenarios can show the exact tick counts. These are the boundary intervals lim_lo and lim_hi-1 passing, an interval of lim_lo-1 failing, the timeout landing on tick lim_hi-1, the unarmed first edge, and the limits being captured in sleep and ignored elsewhere.

// File: rtl/poll_wake_pkg.sv
package poll_wake_pkg;
  typedef enum logic [1:0] {
    M_SLEEP = 2'd0,
    M_START = 2'd1,
    M_CHECK = 2'd2,
    M_RECV  = 2'd3
  } pw_mode_t;
endpackage

// File: rtl/poll_phase_timer.sv
// Counts extended-clock ticks while a timed phase runs; done pulses on the
// tick that completes len ticks (len of zero finishes on the first tick).
module poll_phase_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic [DW-1:0] len,
  output logic          done
);
  logic [DW-1:0] cnt_q;
  logic [DW:0]   next_v;

  assign next_v = {1'b0, cnt_q} + 1'b1;
  assign done   = run && tick && (next_v >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt_q <= '0;
    else if (tick)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/poll_interval_chk.sv
// Measures ticks between sampled demodulator edges and grades each interval.
module poll_interval_chk #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          active,
  input  logic          edge_seen,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          pass,
  output logic          fail
);
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   inc_v;

  assign inc_v = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    pass = 1'b0;
    fail = 1'b0;
    if (active && tick && armed_q) begin
      if (edge_seen) begin
        if (cnt_q < lo) fail = 1'b1;
        else            pass = 1'b1;
      end else if (inc_v >= {1'b0, hi}) begin
        fail = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (tick) begin
      if (edge_seen) begin
        armed_q <= 1'b1;
        cnt_q   <= {{(CW-1){1'b0}}, 1'b1};
      end else if (armed_q && !fail) begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  // R6: a running interval never reaches the upper limit
  assert_count_window_R6: assert property (@(posedge clk) disable iff (rst)
    (armed_q && hi > 1) |-> (cnt_q < hi));
endmodule

// File: rtl/poll_wake_gate.sv
module poll_wake_gate
  import poll_wake_pkg::*;
#(
  parameter int CW = 8,
  parameter int BW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          demod_in,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  input  logic [BW-1:0] bits_req,
  input  logic [DW-1:0] sleep_len,
  input  logic [DW-1:0] start_len,
  input  logic          poll_cmd,
  output logic          rx_en,
  output logic [1:0]    mode,
  output logic          data_sel,
  output logic          data_out
);
  pw_mode_t      mode_q, mode_d;
  logic          smp_q, edge_w;
  logic [CW-1:0] lo_q, hi_q;
  logic [BW-1:0] nreq_q, passed_q;
  logic [BW:0]   pass_inc;
  logic          goal, phase_done, iv_pass, iv_fail, timed_run;
  logic [DW-1:0] phase_len;
  logic          rx_en_q, data_sel_q, data_out_q;

  assign edge_w    = demod_in ^ smp_q;
  assign timed_run = (mode_q == M_SLEEP) || (mode_q == M_START);
  assign phase_len = (mode_q == M_SLEEP) ? sleep_len : start_len;
  assign pass_inc  = {1'b0, passed_q} + 1'b1;
  assign goal      = pass_inc >= {1'b0, nreq_q};

  poll_phase_timer #(.DW(DW)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .run(timed_run),
    .len(phase_len), .done(phase_done)
  );

  poll_interval_chk #(.CW(CW)) u_ivchk (
    .clk(clk), .rst(rst), .tick(tick), .active(mode_q == M_CHECK),
    .edge_seen(edge_w), .lo(lo_q), .hi(hi_q), .pass(iv_pass), .fail(iv_fail)
  );

  always_ff @(posedge clk) begin
    if (rst)       smp_q <= 1'b0;
    else if (tick) smp_q <= demod_in;
  end

  // settings follow the inputs only while asleep
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      nreq_q <= '0;
    end else if (mode_q == M_SLEEP) begin
      lo_q   <= lim_lo;
      hi_q   <= lim_hi;
      nreq_q <= bits_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_q != M_CHECK) passed_q <= '0;
    else if (iv_pass)             passed_q <= passed_q + 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_SLEEP: if (phase_done) mode_d = M_START;
      M_START: if (phase_done) mode_d = M_CHECK;
      M_CHECK: begin
        if (iv_fail)              mode_d = M_SLEEP;
        else if (iv_pass && goal) mode_d = M_RECV;
      end
      M_RECV:  if (tick && poll_cmd) mode_d = M_SLEEP;
      default: mode_d = M_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_SLEEP;
      rx_en_q    <= 1'b0;
      data_sel_q <= 1'b0;
      data_out_q <= 1'b1;
    end else begin
      mode_q     <= mode_d;
      rx_en_q    <= (mode_d != M_SLEEP);
      data_sel_q <= (mode_d == M_RECV);
      data_out_q <= (mode_q == M_RECV) ? smp_q : 1'b1;
    end
  end

  assign mode     = mode_q;
  assign rx_en    = rx_en_q;
  assign data_sel = data_sel_q;
  assign data_out = data_out_q;

  // R2: sleep leads only to startup
  assert_sleep_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP) |=> (mode_q == M_SLEEP || mode_q == M_START));
  // R2: mode moves only on ticks
  assert_tick_only_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mode_q));
  // R3: startup leads only to bitcheck
  assert_start_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_START) |=> (mode_q == M_START || mode_q == M_CHECK));
  // R7: receiving mode is entered only from bitcheck
  assert_recv_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP || mode_q == M_START) |=> (mode_q != M_RECV));
  // R9: receiving mode holds without a command
  assert_recv_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RECV && !(tick && poll_cmd)) |=> (mode_q == M_RECV));
endmodule

// File: tb/poll_wake_gate_bench.sv
module poll_wake_gate_bench;
  localparam int CW = 8, BW = 6, DW = 16;
  localparam int S = 3, T = 2, LO = 4, HI = 8, N = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, demod = 1'b1, poll = 1'b0;
  logic [CW-1:0] lo_i = LO, hi_i = HI;
  logic [BW-1:0] n_i = N;
  logic [DW-1:0] s_i = S, t_i = T;
  logic rx_en, data_sel, data_out;
  logic [1:0] mode;

  always #2 clk = ~clk;

  poll_wake_gate #(.CW(CW), .BW(BW), .DW(DW)) u_poll_wake_gate (
    .clk(clk), .rst(rst), .tick(tick), .demod_in(demod),
    .lim_lo(lo_i), .lim_hi(hi_i), .bits_req(n_i),
    .sleep_len(s_i), .start_len(t_i), .poll_cmd(poll),
    .rx_en(rx_en), .mode(mode), .data_sel(data_sel), .data_out(data_out)
  );

  int  checks = 0, errors = 0;
  bit  lvl = 1'b1;
  bit  cmd = 1'b0;
  bit  finished = 1'b0;

  typedef struct { logic [1:0] m; logic d; string tag; } item_t;
  item_t sb_q[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: one tick with the given level, expectation pushed to the scoreboard
  task automatic step(bit l, logic [1:0] m, string tag);
    item_t it;
    @(negedge clk);
    demod = l; poll = cmd; tick = 1'b1;
    it.m = m; it.d = (m == 2'd3) ? l : 1'b1; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    tick = 1'b0; poll = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares one clock after each tick edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      if (tick === 1'b1) begin
        @(posedge clk);
        #1;
        if (sb_q.size() == 0) chk(1'b0, "SB", "queue", 0, 1);
        else begin
          it = sb_q.pop_front();
          chk(mode == it.m, it.tag, "mode", int'(mode), int'(it.m));
          chk(rx_en == (it.m != 2'd0), it.tag, "rx_en", int'(rx_en), int'(it.m != 2'd0));
          chk(data_sel == (it.m == 2'd3), it.tag, "data_sel", int'(data_sel), int'(it.m == 2'd3));
          chk(data_out == it.d, it.tag, "data_out", int'(data_out), int'(it.d));
        end
      end
    end
  end

  task automatic wake();
    for (int i = 0; i < S - 1; i++) step(lvl, 2'd0, "R2");
    step(lvl, 2'd1, "R2");
    for (int i = 0; i < T - 1; i++) begin lvl = ~lvl; step(lvl, 2'd1, "R3"); end
    lvl = ~lvl;
    step(lvl, 2'd2, "R3");
  endtask

  task automatic arm();
    lvl = ~lvl;
    step(lvl, 2'd2, "R4");
  endtask

  task automatic interval(int d, logic [1:0] fin, string tag);
    for (int i = 0; i < d - 1; i++) step(lvl, 2'd2, tag);
    lvl = ~lvl;
    step(lvl, fin, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mode == 2'd0, "R1", "mode", int'(mode), 0);
    chk(rx_en == 1'b0, "R1", "rx_en", int'(rx_en), 0);
    chk(data_sel == 1'b0, "R1", "data_sel", int'(data_sel), 0);
    chk(data_out == 1'b1, "R1", "data_out", int'(data_out), 1);

    wake();
    for (int i = 0; i < 10; i++) step(lvl, 2'd2, "R4");  // unarmed wait
    arm();
    interval(LO - 1, 2'd0, "R5");                         // too short

    wake(); arm();
    for (int i = 0; i < HI - 2; i++) step(lvl, 2'd2, "R6");
    step(lvl, 2'd0, "R6");                                // timeout

    wake(); arm();
    lo_i = 10; hi_i = 5; n_i = 1;                          // not captured
    interval(LO, 2'd2, "R10");
    cmd = 1'b1;
    interval(HI - 1, 2'd2, "R9");                         // command ignored
    cmd = 1'b0;
    interval(5, 2'd3, "R7");
    lo_i = 2; hi_i = HI; n_i = N;

    step(1'b0, 2'd3, "R8"); lvl = 1'b0;
    step(1'b1, 2'd3, "R8"); lvl = 1'b1;
    step(1'b1, 2'd3, "R8");
    step(1'b0, 2'd3, "R8"); lvl = 1'b0;
    for (int i = 0; i < 30; i++) step(lvl, 2'd3, "R9");
    cmd = 1'b1;
    step(lvl, 2'd0, "R9");
    cmd = 1'b0;

    wake(); arm();
    interval(3, 2'd2, "R10");                            // new lower limit 2
    interval(LO, 2'd2, "R7");
    interval(HI - 1, 2'd3, "R7");

    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "SB", "leftover", sb_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule